// File: doc/BRIEF.md
# Multiplexer Carry Chain Adder

This block adds two K-bit operands and a carry input. It treats the operands as either unsigned or two's-complement numbers. Every bit position forms a propagate term from the exclusive-OR of its two operand bits. A 2:1 multiplexer then steers the carry onward. When the propagate term is high, the multiplexer passes the incoming carry. When it is low, the multiplexer passes the second operand bit. This is the same structure as the dedicated carry chains found in FPGA logic cells.

The sum bit is the propagate term exclusive-ORed with the carry into that bit. The carry out is the carry leaving the top stage. The signed overflow flag is the exclusive-OR of the carries into and out of the top stage. The carry ripples through every stage, so the delay of the chain grows linearly with K.

The parameter OUT_REG selects an output register stage. Its default is 1, which gives a latency of one clock with a synchronous active-high reset. Setting it to 0 leaves a purely combinational path.

Top module: `mcc_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge clears `s`, `cout` and `ovf` to zero, whatever the operands are.
- R2: With the default output register, `{cout, s}` equals the unsigned `x + y + cin` of the operands sampled at the previous rising edge.
- R3: When every bit of `x ^ y` is 1 (full propagate), the carry input passes through the whole chain: every bit of `s` equals the inverse of `cin`, and `cout` equals `cin`.
- R4: `ovf` is 1 exactly when `x[K-1]` equals `y[K-1]` and `s[K-1]` differs from them. This means two non-negative values gave a negative result, or two negative values gave a non-negative one. Operands of opposite sign never raise `ovf`.
- R5: An all-ones operand plus 1 wraps to zero with `cout` = 1 and `ovf` = 0. The 1 may come from `y` or from `cin`.
- R6: The most positive value (0 followed by ones) plus 1 gives the most negative value (1 followed by zeros), with `ovf` = 1 and `cout` = 0.
- R7: The most negative value added to itself gives zero, with `cout` = 1 and `ovf` = 1.
- R8: When `x` equals `y` (no bit propagates), each carry is the operand bit below it. So `s` equals `{x[K-2:0], cin}` and `cout` equals `x[K-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| x | input | K | First operand |
| y | input | K | Second operand; also the carry source of a non-propagating bit |
| cin | input | 1 | Carry into bit 0 |
| s | output | K | Sum |
| cout | output | 1 | Carry out of the top bit |
| ovf | output | 1 | Two's-complement overflow |

## Verification
Several operand patterns each drive the carry multiplexers along a different path:

- Alternating complementary words make every bit propagate, so the carry input is the only thing that reaches the top (R3).
- Equal operands make no bit propagate, so each carry comes straight from the operand bit below it (R8).
- The all-ones plus one, most-positive plus one and most-negative doubled vectors set apart the carry-out and overflow flags, which differ in exactly those cases (R5, R6, R7).
- Random vectors compared against an arithmetic reference cover mixed chains of propagate and non-propagate bits.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  // Per-bit carry-steering decision: propagate select and the bit
  // forwarded when the stage does not propagate.
  typedef struct packed {
    logic prop;
    logic gen;
  } mcc_pg_t;

  function automatic mcc_pg_t mcc_pg(input logic a, input logic b);
    mcc_pg_t r;
    r.prop = a ^ b;
    r.gen  = b;
    return r;
  endfunction

endpackage

// File: rtl/mcc_cell.sv
module mcc_cell
  import mcc_pkg::*;
(
  input  logic xi,
  input  logic yi,
  input  logic ci,
  output logic co,
  output logic si
);

  mcc_pg_t pg;

  always_comb begin
    pg = mcc_pg(xi, yi);
    // 2:1 steering: propagate passes the incoming carry,
    // otherwise the operand bit becomes the carry.
    co = pg.prop ? ci : pg.gen;
    si = pg.prop ^ ci;
  end

endmodule

// File: rtl/mcc_chain.sv
module mcc_chain #(
  parameter int K = 16
) (
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  input  logic         cin,
  output logic [K-1:0] s,
  output logic         c_top,
  output logic         c_below
);

  logic [K:0] c;

  assign c[0] = cin;

  for (genvar i = 0; i < K; i++) begin : g_stage
    mcc_cell u_cell (
      .xi (x[i]),
      .yi (y[i]),
      .ci (c[i]),
      .co (c[i+1]),
      .si (s[i])
    );
  end

  assign c_top   = c[K];
  assign c_below = c[K-1];

endmodule

// File: rtl/mcc_flags.sv
module mcc_flags (
  input  logic c_top,
  input  logic c_below,
  output logic cout,
  output logic ovf
);

  assign cout = c_top;
  assign ovf  = c_top ^ c_below;

endmodule

// File: rtl/mcc_outreg.sv
module mcc_outreg #(
  parameter int W  = 18,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (EN) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end

endmodule

// File: rtl/mcc_adder.sv
module mcc_adder #(
  parameter int K       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  input  logic         cin,
  output logic [K-1:0] s,
  output logic         cout,
  output logic         ovf
);

  localparam int W = K + 2;

  initial begin
    if (K < 2) $error("mcc_adder: K must be at least 2");
  end

  logic [K-1:0] sum_c;
  logic         c_top, c_below;
  logic         cout_c, ovf_c;
  logic [W-1:0] res_q;

  mcc_chain #(.K(K)) u_chain (
    .x       (x),
    .y       (y),
    .cin     (cin),
    .s       (sum_c),
    .c_top   (c_top),
    .c_below (c_below)
  );

  mcc_flags u_flags (
    .c_top   (c_top),
    .c_below (c_below),
    .cout    (cout_c),
    .ovf     (ovf_c)
  );

  mcc_outreg #(.W(W), .EN(OUT_REG)) u_out (
    .clk (clk),
    .rst (rst),
    .d   ({ovf_c, cout_c, sum_c}),
    .q   (res_q)
  );

  assign s    = res_q[K-1:0];
  assign cout = res_q[K];
  assign ovf  = res_q[K+1];

endmodule

// File: rtl/mcc_adder_chk.sv
module mcc_adder_chk #(
  parameter int K       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [K-1:0] x,
  input logic [K-1:0] y,
  input logic         cin,
  input logic [K-1:0] s,
  input logic         cout,
  input logic         ovf
);

  if (OUT_REG) begin : g_seq
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (s == '0 && !cout && !ovf)); // R1

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ({cout, s} == ({1'b0, $past(x)} + {1'b0, $past(y)}
                                     + {{K{1'b0}}, $past(cin)}))); // R2

    AST_FULL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(x ^ y) == {K{1'b1}}))
        |-> (s == {K{~$past(cin)}} && cout == $past(cin))); // R3

    AST_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (ovf == (($past(x[K-1]) == $past(y[K-1]))
                               && (s[K-1] != $past(x[K-1]))))); // R4

    AST_NO_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(x) == $past(y)))
        |-> (s == {$past(x[K-2:0]), $past(cin)} && cout == $past(x[K-1]))); // R8
  end else begin : g_comb
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
      {cout, s} == ({1'b0, x} + {1'b0, y} + {{K{1'b0}}, cin})); // R2

    AST_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      ovf == ((x[K-1] == y[K-1]) && (s[K-1] != x[K-1]))); // R4

    AST_FULL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
      ((x ^ y) == {K{1'b1}}) |-> (s == {K{~cin}} && cout == cin)); // R3

    AST_NO_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
      (x == y) |-> (s == {x[K-2:0], cin} && cout == x[K-1])); // R8
  end

endmodule

bind mcc_adder mcc_adder_chk #(.K(K), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tb_mcc_adder.sv
module tb_mcc_adder;

  localparam int K  = 16;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [K-1:0] x   = '0;
  logic [K-1:0] y   = '0;
  logic         cin = 1'b0;
  logic [K-1:0] s;
  logic         cout;
  logic         ovf;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mcc_adder #(.K(K), .OUT_REG(1'b1)) dut (
    .clk (clk), .rst (rst), .x (x), .y (y), .cin (cin),
    .s (s), .cout (cout), .ovf (ovf)
  );

  // Stimulus {x, y, cin} and expected {ovf, cout, s}.
  localparam logic [K-1:0] TX [NV] = '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h7FFF,
    16'h8000, 16'h1234, 16'hAAAA, 16'hAAAA, 16'h3C3C, 16'hC3C3, 16'h8000,
    16'h4000, 16'h7FFF};
  localparam logic [K-1:0] TY [NV] = '{16'h0000, 16'h0001, 16'h0000, 16'h0001,
    16'h8000, 16'h5678, 16'h5555, 16'h5555, 16'h3C3C, 16'hC3C3, 16'hFFFF,
    16'h4000, 16'h8000};
  localparam logic TC [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
    1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [K+1:0] TE [NV] = '{
    {2'b00, 16'h0000}, {2'b01, 16'h0000}, {2'b01, 16'h0000}, {2'b10, 16'h8000},
    {2'b11, 16'h0000}, {2'b00, 16'h68AC}, {2'b01, 16'h0000}, {2'b00, 16'hFFFF},
    {2'b00, 16'h7879}, {2'b01, 16'h8786}, {2'b11, 16'h7FFF}, {2'b10, 16'h8000},
    {2'b01, 16'h0000}};
  localparam string TR [NV] = '{"R2", "R5", "R5", "R6", "R7", "R2", "R3", "R3",
    "R8", "R8", "R4", "R4", "R4"};

  task automatic check(input string req, input logic [K+1:0] act,
                       input logic [K+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {ovf,cout,s}=%h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, the register captures at the next rising
  // edge, sample at the falling edge after it.
  task automatic apply(input logic [K-1:0] a, input logic [K-1:0] b,
                       input logic c);
    @(negedge clk);
    x = a; y = b; cin = c;
    @(negedge clk);
  endtask

  function automatic logic [K+1:0] model(input logic [K-1:0] a,
                                         input logic [K-1:0] b, input logic c);
    logic [K:0] t;
    logic       v;
    t = {1'b0, a} + {1'b0, b} + {{K{1'b0}}, c};
    v = (a[K-1] == b[K-1]) && (t[K-1] != a[K-1]);
    return {v, t};
  endfunction

  initial begin
    // R1: reset with non-zero operands keeps outputs cleared
    x = 16'hFFFF; y = 16'h0001; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", {ovf, cout, s}, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(TX[i], TY[i], TC[i]);
      check(TR[i], {ovf, cout, s}, TE[i]);
    end

    // R2: random vectors against the arithmetic reference
    for (int i = 0; i < 200; i++) begin
      logic [K-1:0] a, b;
      logic         c;
      a = K'($urandom);
      b = K'($urandom);
      c = 1'($urandom);
      apply(a, b, c);
      check("R2 random", {ovf, cout, s}, model(a, b, c));
    end

    // R1: reset mid-run clears a result that would set every flag
    @(negedge clk);
    x = 16'h8000; y = 16'h8000; cin = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", {ovf, cout, s}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 after reset", {ovf, cout, s}, {2'b11, 16'h0001});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got running expected finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule